// File: doc/BRIEF.md
# Data Register Transfer Unit

This block moves half-words between a 16-bit operand bus and the data registers of a signal-processing core. The registers are a single-word multiplier input register `x`, a double-word multiplier input register `y`, and a small bank of extended accumulators. Each accumulator holds a double word plus guard bits. An instruction decoder presents one transfer code per cycle. The unit performs loads into either half of a register on the rising clock edge. It performs stores from either half of a register onto the output bus combinationally, within the same cycle.

Two mode bits control what a high-half load does to the low half. One applies to `y` and the other to the accumulators. When set, the low half is zeroed. A third mode bit turns on limiting of accumulator stores. With limiting on, a store from an accumulator whose guard bits show an overflow places the largest positive or negative half-word pattern on the bus. The accumulator itself is never changed by a store.

Arithmetic is done outside this block. Its results enter through a separate accumulator write port. In the same cycle, a bus load has priority over that port.

Top module: `dreg_xfer_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it rises, `x_o`, `y_o` and every accumulator read zero, and `ybus_oe_o` is low.
- R2: Transfer code 1 (load y high) writes `ybus_i` into y bits 31..16 at the next rising edge. Bits 15..0 become zero when `clr_y_en_i` is 1 and are kept otherwise.
- R3: Transfer code 2 (load y low) writes `ybus_i` into y bits 15..0 and leaves bits 31..16 unchanged.
- R4: Transfer code 3 (load accumulator high) writes `ybus_i` into bits 31..16 of the accumulator chosen by `acc_sel_i` and copies bit 31 into guard bits 35..32. Bits 15..0 become zero when `clr_acc_en_i` is 1 and are kept otherwise.
- R5: Transfer code 4 (load accumulator low) writes `ybus_i` into bits 15..0 of the chosen accumulator and leaves bits 35..16 unchanged.
- R6: Transfer code 7 loads y bits 31..16 from bits 31..16 of the chosen accumulator and, in the same edge, loads `x` from `xbus_i`. The clearing rule of R2 applies to y bits 15..0.
- R7: Transfer code 6 loads y bits 31..16 from `ybus_i` and `x` from `xbus_i` in one edge, with the R2 clearing rule. Transfer code 5 loads `x` from `ybus_i` alone.
- R8: Transfer codes 8 and 9 drive y bits 31..16 and y bits 15..0 respectively onto `ybus_o` in the same cycle, never limited. Whenever the code is 8, 9, 10 or 11, `ybus_oe_o` is 1, and otherwise it is 0 with `ybus_o` at zero.
- R9: Transfer codes 10 and 11 drive bits 31..16 and bits 15..0 of the chosen accumulator onto `ybus_o`. The value is unchanged when `sat_en_i` is 0 or when the accumulator is not overflowed. An accumulator is overflowed when bits 35..31 are not all equal.
- R10: With `sat_en_i` at 1 and an overflowed accumulator, code 10 drives 0x7FFF if bit 35 is 0 and 0x8000 if it is 1. Code 11 drives 0xFFFF if bit 35 is 0 and 0x0000 if it is 1.
- R11: Code 0, codes 8 to 11 and unused codes 12 to 15 modify no register.
- R12: `alu_we_i` writes `alu_val_i` into the accumulator chosen by `alu_sel_i` at the next edge. A bus load to the same accumulator in the same cycle takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_i | input | 4 | Transfer code for this cycle |
| acc_sel_i | input | 1 | Accumulator chosen by the transfer |
| ybus_i | input | 16 | Primary operand bus, load data |
| xbus_i | input | 16 | Secondary operand bus, x load data for codes 6 and 7 |
| clr_y_en_i | input | 1 | Zero y low half on y high loads |
| clr_acc_en_i | input | 1 | Zero accumulator low half on accumulator high loads |
| sat_en_i | input | 1 | Limit accumulator stores on overflow |
| alu_we_i | input | 1 | Arithmetic result write enable |
| alu_sel_i | input | 1 | Accumulator written by the arithmetic port |
| alu_val_i | input | 36 | Arithmetic result value |
| ybus_o | output | 16 | Store data |
| ybus_oe_o | output | 1 | Store data valid |
| x_o | output | 16 | Current x register |
| y_o | output | 32 | Current y register |
| acc_flat_o | output | 72 | All accumulators, accumulator 0 in the low bits |

## Verification
Random transfer codes are mixed with arithmetic-port writes whose guard bits are drawn at random. This mix reaches overflowed positive values, overflowed negative values and clean values of both signs. As a result, stores with limiting on show whether the overflow test and the sign choice are correct. Both clear-mode bits are toggled randomly under high loads, which separates kept low halves from zeroed ones. Directed cases then target four situations:
- a negative high load, which distinguishes sign fill from zero fill;
- each overflow direction with limiting on and with limiting off;
- a same-cycle collision between a bus load and an arithmetic write;
- a store followed by a read of the registers, to confirm the store left them unchanged.

// File: rtl/dxu_pkg.sv
package dxu_pkg;

   typedef enum logic [3:0] {
      XOP_NOP     = 4'd0,
      XOP_LD_YH   = 4'd1,
      XOP_LD_YL   = 4'd2,
      XOP_LD_AH   = 4'd3,
      XOP_LD_AL   = 4'd4,
      XOP_LD_X    = 4'd5,
      XOP_LD_YH_X = 4'd6,
      XOP_LD_YA_X = 4'd7,
      XOP_ST_YH   = 4'd8,
      XOP_ST_YL   = 4'd9,
      XOP_ST_AH   = 4'd10,
      XOP_ST_AL   = 4'd11
   } xop_e;

   typedef struct packed {
      logic yh_from_bus;
      logic yh_from_acc;
      logic yl_from_bus;
      logic x_from_ybus;
      logic x_from_xbus;
      logic ah_from_bus;
      logic al_from_bus;
      logic st_yh;
      logic st_yl;
      logic st_ah;
      logic st_al;
   } xfer_ctl_t;

   localparam xfer_ctl_t XFER_IDLE = '0;

endpackage

// File: rtl/dxu_decode.sv
module dxu_decode
   import dxu_pkg::*;
(
   input  logic [3:0] op_i,
   output xfer_ctl_t  ctl_o
);

   always_comb begin
      ctl_o = XFER_IDLE;
      case (op_i)
         XOP_LD_YH:   ctl_o.yh_from_bus = 1'b1;
         XOP_LD_YL:   ctl_o.yl_from_bus = 1'b1;
         XOP_LD_AH:   ctl_o.ah_from_bus = 1'b1;
         XOP_LD_AL:   ctl_o.al_from_bus = 1'b1;
         XOP_LD_X:    ctl_o.x_from_ybus = 1'b1;
         XOP_LD_YH_X: begin
            ctl_o.yh_from_bus = 1'b1;
            ctl_o.x_from_xbus = 1'b1;
         end
         XOP_LD_YA_X: begin
            ctl_o.yh_from_acc = 1'b1;
            ctl_o.x_from_xbus = 1'b1;
         end
         XOP_ST_YH:   ctl_o.st_yh = 1'b1;
         XOP_ST_YL:   ctl_o.st_yl = 1'b1;
         XOP_ST_AH:   ctl_o.st_ah = 1'b1;
         XOP_ST_AL:   ctl_o.st_al = 1'b1;
         default:     ctl_o = XFER_IDLE;
      endcase
   end

endmodule

// File: rtl/dxu_xy_regs.sv
module dxu_xy_regs #(
   parameter int DW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          yh_from_bus_i,
   input  logic          yh_from_acc_i,
   input  logic          yl_from_bus_i,
   input  logic          x_from_ybus_i,
   input  logic          x_from_xbus_i,
   input  logic          clr_y_en_i,
   input  logic [DW-1:0] ybus_i,
   input  logic [DW-1:0] xbus_i,
   input  logic [DW-1:0] acc_hi_i,
   output logic [DW-1:0]   x_o,
   output logic [2*DW-1:0] y_o
);

   localparam int YW = 2 * DW;

   logic [DW-1:0] x_q;
   logic [YW-1:0] y_q;
   logic [DW-1:0] yh_src;
   logic          yh_load;

   assign yh_load = yh_from_bus_i | yh_from_acc_i;
   assign yh_src  = yh_from_acc_i ? acc_hi_i : ybus_i;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         y_q <= '0;
      end else if (yh_load) begin
         y_q[YW-1:DW] <= yh_src;
         if (clr_y_en_i) y_q[DW-1:0] <= '0;
      end else if (yl_from_bus_i) begin
         y_q[DW-1:0] <= ybus_i;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         x_q <= '0;
      end else if (x_from_xbus_i) begin
         x_q <= xbus_i;
      end else if (x_from_ybus_i) begin
         x_q <= ybus_i;
      end
   end

   assign x_o = x_q;
   assign y_o = y_q;

endmodule

// File: rtl/dxu_acc_slot.sv
module dxu_acc_slot #(
   parameter int DW = 16,
   parameter int GW = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ld_hi_i,
   input  logic               ld_lo_i,
   input  logic               clr_lo_en_i,
   input  logic [DW-1:0]      bus_i,
   input  logic               alu_we_i,
   input  logic [2*DW+GW-1:0] alu_val_i,
   output logic [2*DW+GW-1:0] acc_o
);

   localparam int AW = 2 * DW + GW;

   logic [AW-1:0] acc_q;
   logic [AW-1:0] hi_word;

   always_comb begin
      hi_word             = acc_q;
      hi_word[AW-1:2*DW]  = {GW{bus_i[DW-1]}};
      hi_word[2*DW-1:DW]  = bus_i;
      if (clr_lo_en_i) hi_word[DW-1:0] = '0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc_q <= '0;
      end else if (ld_hi_i) begin
         acc_q <= hi_word;
      end else if (ld_lo_i) begin
         acc_q[DW-1:0] <= bus_i;
      end else if (alu_we_i) begin
         acc_q <= alu_val_i;
      end
   end

   assign acc_o = acc_q;

endmodule

// File: rtl/dxu_store_path.sv
module dxu_store_path #(
   parameter int DW      = 16,
   parameter int GW      = 4,
   parameter bit HAS_SAT = 1'b1
) (
   input  logic               st_yh_i,
   input  logic               st_yl_i,
   input  logic               st_ah_i,
   input  logic               st_al_i,
   input  logic               sat_en_i,
   input  logic [2*DW-1:0]    y_i,
   input  logic [2*DW+GW-1:0] acc_i,
   output logic [DW-1:0]      bus_o,
   output logic               oe_o
);

   localparam int AW = 2 * DW + GW;

   logic [DW-1:0] acc_hi_out;
   logic [DW-1:0] acc_lo_out;

   generate
      if (HAS_SAT) begin : g_sat
         logic [GW:0]   top_bits;
         logic          ovf;
         logic          neg;
         logic [DW-1:0] lim_hi;
         logic [DW-1:0] lim_lo;
         assign top_bits = acc_i[AW-1:2*DW-1];
         assign ovf      = ~((&top_bits) | ~(|top_bits));
         assign neg      = acc_i[AW-1];
         assign lim_hi   = neg ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
         assign lim_lo   = neg ? {DW{1'b0}} : {DW{1'b1}};
         assign acc_hi_out = (sat_en_i && ovf) ? lim_hi : acc_i[2*DW-1:DW];
         assign acc_lo_out = (sat_en_i && ovf) ? lim_lo : acc_i[DW-1:0];
      end else begin : g_raw
         logic unused_guard;
         assign unused_guard = sat_en_i ^ (^acc_i[AW-1:2*DW]);
         assign acc_hi_out   = acc_i[2*DW-1:DW];
         assign acc_lo_out   = acc_i[DW-1:0];
      end
   endgenerate

   always_comb begin
      bus_o = '0;
      unique case (1'b1)
         st_yh_i: bus_o = y_i[2*DW-1:DW];
         st_yl_i: bus_o = y_i[DW-1:0];
         st_ah_i: bus_o = acc_hi_out;
         st_al_i: bus_o = acc_lo_out;
         default: bus_o = '0;
      endcase
   end

   assign oe_o = st_yh_i | st_yl_i | st_ah_i | st_al_i;

endmodule

// File: rtl/dreg_xfer_unit.sv
module dreg_xfer_unit
   import dxu_pkg::*;
#(
   parameter int DW      = 16,
   parameter int GW      = 4,
   parameter int NUM_ACC = 2,
   parameter bit HAS_SAT = 1'b1,
   localparam int AW     = 2 * DW + GW,
   localparam int SELW   = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [3:0]            op_i,
   input  logic [SELW-1:0]       acc_sel_i,
   input  logic [DW-1:0]         ybus_i,
   input  logic [DW-1:0]         xbus_i,
   input  logic                  clr_y_en_i,
   input  logic                  clr_acc_en_i,
   input  logic                  sat_en_i,
   input  logic                  alu_we_i,
   input  logic [SELW-1:0]       alu_sel_i,
   input  logic [AW-1:0]         alu_val_i,
   output logic [DW-1:0]         ybus_o,
   output logic                  ybus_oe_o,
   output logic [DW-1:0]         x_o,
   output logic [2*DW-1:0]       y_o,
   output logic [NUM_ACC*AW-1:0] acc_flat_o
);

   if (DW < 2) begin : g_bad_dw
      $error("dreg_xfer_unit: DW must be at least 2");
   end
   if (GW < 1) begin : g_bad_gw
      $error("dreg_xfer_unit: GW must be at least 1");
   end
   if (NUM_ACC < 1 || NUM_ACC > 16) begin : g_bad_nacc
      $error("dreg_xfer_unit: NUM_ACC must be 1..16");
   end

   xfer_ctl_t     ctl;
   logic [AW-1:0] acc_q [NUM_ACC];
   logic [AW-1:0] acc_pick;

   dxu_decode u_dec (
      .op_i  (op_i),
      .ctl_o (ctl)
   );

   always_comb begin
      acc_pick = '0;
      for (int i = 0; i < NUM_ACC; i++) begin
         if (acc_sel_i == SELW'(i)) acc_pick = acc_q[i];
      end
   end

   dxu_xy_regs #(.DW(DW)) u_xy (
      .clk           (clk),
      .rst_n         (rst_n),
      .yh_from_bus_i (ctl.yh_from_bus),
      .yh_from_acc_i (ctl.yh_from_acc),
      .yl_from_bus_i (ctl.yl_from_bus),
      .x_from_ybus_i (ctl.x_from_ybus),
      .x_from_xbus_i (ctl.x_from_xbus),
      .clr_y_en_i    (clr_y_en_i),
      .ybus_i        (ybus_i),
      .xbus_i        (xbus_i),
      .acc_hi_i      (acc_pick[2*DW-1:DW]),
      .x_o           (x_o),
      .y_o           (y_o)
   );

   for (genvar g = 0; g < NUM_ACC; g++) begin : g_acc
      logic hit_bus;
      logic hit_alu;
      assign hit_bus = (acc_sel_i == SELW'(g));
      assign hit_alu = alu_we_i && (alu_sel_i == SELW'(g));

      dxu_acc_slot #(.DW(DW), .GW(GW)) u_slot (
         .clk         (clk),
         .rst_n       (rst_n),
         .ld_hi_i     (ctl.ah_from_bus & hit_bus),
         .ld_lo_i     (ctl.al_from_bus & hit_bus),
         .clr_lo_en_i (clr_acc_en_i),
         .bus_i       (ybus_i),
         .alu_we_i    (hit_alu),
         .alu_val_i   (alu_val_i),
         .acc_o       (acc_q[g])
      );

      assign acc_flat_o[g*AW +: AW] = acc_q[g];
   end

   dxu_store_path #(.DW(DW), .GW(GW), .HAS_SAT(HAS_SAT)) u_st (
      .st_yh_i  (ctl.st_yh),
      .st_yl_i  (ctl.st_yl),
      .st_ah_i  (ctl.st_ah),
      .st_al_i  (ctl.st_al),
      .sat_en_i (sat_en_i),
      .y_i      (y_o),
      .acc_i    (acc_pick),
      .bus_o    (ybus_o),
      .oe_o     (ybus_oe_o)
   );

endmodule

// File: rtl/dxu_checker.sv
module dxu_checker #(
   parameter int DW      = 16,
   parameter int GW      = 4,
   parameter int NUM_ACC = 2,
   parameter bit HAS_SAT = 1'b1,
   localparam int AW     = 2 * DW + GW,
   localparam int SELW   = (NUM_ACC > 1) ? $clog2(NUM_ACC) : 1
) (
   input logic                  clk,
   input logic                  rst_n,
   input logic [3:0]            op_i,
   input logic [SELW-1:0]       acc_sel_i,
   input logic [DW-1:0]         ybus_i,
   input logic [DW-1:0]         xbus_i,
   input logic                  clr_y_en_i,
   input logic                  clr_acc_en_i,
   input logic                  sat_en_i,
   input logic                  alu_we_i,
   input logic [SELW-1:0]       alu_sel_i,
   input logic [AW-1:0]         alu_val_i,
   input logic [DW-1:0]         ybus_o,
   input logic                  ybus_oe_o,
   input logic [DW-1:0]         x_o,
   input logic [2*DW-1:0]       y_o,
   input logic [NUM_ACC*AW-1:0] acc_flat_o
);

   function automatic logic [AW-1:0] acc_at(input logic [SELW-1:0] idx);
      logic [AW-1:0] r;
      r = '0;
      for (int i = 0; i < NUM_ACC; i++)
         if (idx == SELW'(i)) r = acc_flat_o[i*AW +: AW];
      return r;
   endfunction

   function automatic logic acc_ovf(input logic [AW-1:0] a);
      return !((&a[AW-1:2*DW-1]) || !(|a[AW-1:2*DW-1]));
   endfunction

   logic is_store;
   assign is_store = (op_i >= 4'd8) && (op_i <= 4'd11);

   AST_OE_ON_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      ybus_oe_o == is_store); // R8

   AST_YL_KEEPS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 4'd2) |=> (y_o[2*DW-1:DW] == $past(y_o[2*DW-1:DW])) &&
                         (y_o[DW-1:0] == $past(ybus_i))); // R3

   AST_GUARD_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 4'd3) |=> (acc_at($past(acc_sel_i))[AW-1:2*DW] ==
                          {GW{$past(ybus_i[DW-1])}})); // R4

   AST_STORE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (is_store && !alu_we_i) |=> ($stable(acc_flat_o) && $stable(y_o) && $stable(x_o))); // R11

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      (op_i == 4'd10 && !acc_ovf(acc_at(acc_sel_i))) |->
         (ybus_o == acc_at(acc_sel_i)[2*DW-1:DW])); // R9

   AST_SAT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (HAS_SAT && op_i == 4'd10 && sat_en_i && acc_ovf(acc_at(acc_sel_i))) |->
         (ybus_o == {1'b0, {(DW-1){1'b1}}} || ybus_o == {1'b1, {(DW-1){1'b0}}})); // R10

endmodule

bind dreg_xfer_unit dxu_checker #(
   .DW(DW), .GW(GW), .NUM_ACC(NUM_ACC), .HAS_SAT(HAS_SAT)
) u_chk (.*);

// File: tb/dreg_xfer_unit_test.sv
module dreg_xfer_unit_test;

   localparam int DW = 16;
   localparam int AW = 36;

   logic          clk = 1'b0;
   logic          rst_n;
   logic [3:0]    op_i;
   logic [0:0]    acc_sel_i;
   logic [15:0]   ybus_i, xbus_i;
   logic          clr_y_en_i, clr_acc_en_i, sat_en_i;
   logic          alu_we_i;
   logic [0:0]    alu_sel_i;
   logic [35:0]   alu_val_i;
   logic [15:0]   ybus_o;
   logic          ybus_oe_o;
   logic [15:0]   x_o;
   logic [31:0]   y_o;
   logic [71:0]   acc_flat_o;

   logic [15:0]   m_x;
   logic [31:0]   m_y;
   logic [35:0]   m_acc [2];

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   dreg_xfer_unit uut (
      .clk(clk), .rst_n(rst_n), .op_i(op_i), .acc_sel_i(acc_sel_i),
      .ybus_i(ybus_i), .xbus_i(xbus_i), .clr_y_en_i(clr_y_en_i),
      .clr_acc_en_i(clr_acc_en_i), .sat_en_i(sat_en_i), .alu_we_i(alu_we_i),
      .alu_sel_i(alu_sel_i), .alu_val_i(alu_val_i), .ybus_o(ybus_o),
      .ybus_oe_o(ybus_oe_o), .x_o(x_o), .y_o(y_o), .acc_flat_o(acc_flat_o)
   );

   task automatic check(input bit ok, input string req, input logic [63:0] act,
                        input logic [63:0] exp, input string what);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic string req_of(input logic [3:0] op);
      case (op)
         4'd1: return "R2";
         4'd2: return "R3";
         4'd3: return "R4";
         4'd4: return "R5";
         4'd5: return "R7";
         4'd6: return "R7";
         4'd7: return "R6";
         4'd8, 4'd9: return "R8";
         4'd10, 4'd11: return "R9/R10";
         default: return "R11";
      endcase
   endfunction

   function automatic bit ovf_of(input logic [35:0] a);
      return !(a[35:31] == 5'b00000 || a[35:31] == 5'b11111);
   endfunction

   function automatic logic [15:0] exp_store(input logic [3:0] op, input logic sel,
                                             input logic sat);
      logic [35:0] a;
      a = m_acc[sel];
      case (op)
         4'd8:  return m_y[31:16];
         4'd9:  return m_y[15:0];
         4'd10: return (sat && ovf_of(a)) ? (a[35] ? 16'h8000 : 16'h7FFF) : a[31:16];
         4'd11: return (sat && ovf_of(a)) ? (a[35] ? 16'h0000 : 16'hFFFF) : a[15:0];
         default: return 16'h0000;
      endcase
   endfunction

   task automatic model_update(input logic [3:0] op, input logic sel, input logic [15:0] yb,
                               input logic [15:0] xb, input logic cy, input logic ca,
                               input logic awe, input logic asel, input logic [35:0] aval);
      logic [31:0] ny;
      logic [15:0] nx;
      logic [35:0] nacc [2];
      ny = m_y; nx = m_x; nacc[0] = m_acc[0]; nacc[1] = m_acc[1];
      if (awe) nacc[asel] = aval;
      case (op)
         4'd1: begin ny[31:16] = yb; if (cy) ny[15:0] = 16'h0; end
         4'd2: ny[15:0] = yb;
         4'd3: begin
            nacc[sel] = {{4{yb[15]}}, yb, ca ? 16'h0 : m_acc[sel][15:0]};
         end
         4'd4: nacc[sel] = {m_acc[sel][35:16], yb};
         4'd5: nx = yb;
         4'd6: begin ny[31:16] = yb; if (cy) ny[15:0] = 16'h0; nx = xb; end
         4'd7: begin ny[31:16] = m_acc[sel][31:16]; if (cy) ny[15:0] = 16'h0; nx = xb; end
         default: ;
      endcase
      m_y = ny; m_x = nx; m_acc[0] = nacc[0]; m_acc[1] = nacc[1];
   endtask

   task automatic cycle(input logic [3:0] op, input logic sel, input logic [15:0] yb,
                        input logic [15:0] xb, input logic cy, input logic ca, input logic sat,
                        input logic awe, input logic asel, input logic [35:0] aval,
                        input bit chk_regs);
      string r;
      bit st;
      r = req_of(op);
      st = (op >= 4'd8 && op <= 4'd11);
      @(negedge clk);
      op_i = op; acc_sel_i = sel; ybus_i = yb; xbus_i = xb; clr_y_en_i = cy;
      clr_acc_en_i = ca; sat_en_i = sat; alu_we_i = awe; alu_sel_i = asel; alu_val_i = aval;
      #2;
      check(ybus_oe_o == st, "R8", 64'(ybus_oe_o), 64'(st), "store enable");
      if (st)
         check(ybus_o == exp_store(op, sel, sat), r, 64'(ybus_o),
               64'(exp_store(op, sel, sat)), "store data");
      model_update(op, sel, yb, xb, cy, ca, awe, asel, aval);
      @(posedge clk);
      #1;
      if (awe) r = {r, "/R12"};
      if (chk_regs) begin
         check(x_o == m_x, r, 64'(x_o), 64'(m_x), "x");
         check(y_o == m_y, r, 64'(y_o), 64'(m_y), "y");
         check(acc_flat_o[35:0] == m_acc[0], r, 64'(acc_flat_o[35:0]), 64'(m_acc[0]), "acc0");
         check(acc_flat_o[71:36] == m_acc[1], r, 64'(acc_flat_o[71:36]), 64'(m_acc[1]), "acc1");
      end
   endtask

   function automatic logic [35:0] rand_acc();
      logic [35:0] v;
      v = {$urandom(), $urandom()};
      case ($urandom_range(0, 3))
         0: v[35:31] = 5'b00000;
         1: v[35:31] = 5'b11111;
         default: ;
      endcase
      return v;
   endfunction

   initial begin
      #2_000_000;
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h1F2E3D4C));
      rst_n = 1'b0; op_i = 4'd0; acc_sel_i = 1'b0; ybus_i = 16'hFFFF; xbus_i = 16'hFFFF;
      clr_y_en_i = 1'b0; clr_acc_en_i = 1'b0; sat_en_i = 1'b0; alu_we_i = 1'b0;
      alu_sel_i = 1'b0; alu_val_i = '1;
      m_x = '0; m_y = '0; m_acc[0] = '0; m_acc[1] = '0;
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      check(x_o == 16'h0 && y_o == 32'h0, "R1", 64'({x_o, y_o}), 64'h0, "xy reset");
      check(acc_flat_o == 72'h0, "R1", 64'(acc_flat_o), 64'h0, "acc reset");
      check(ybus_oe_o == 1'b0, "R1", 64'(ybus_oe_o), 64'h0, "oe reset");
      @(negedge clk);
      rst_n = 1'b1;
      alu_val_i = '0;

      // directed: R4 negative high load, sign fill, low kept then cleared
      cycle(4'd4, 1'b1, 16'hABCD, 16'h0, 0, 0, 0, 0, 0, '0, 1); // R5
      cycle(4'd3, 1'b1, 16'h8001, 16'h0, 0, 0, 0, 0, 0, '0, 1); // R4 keep low
      check(acc_flat_o[71:36] == 36'hF_8001_ABCD, "R4", 64'(acc_flat_o[71:36]),
            64'h0000000F8001ABCD, "sign fill");
      cycle(4'd3, 1'b1, 16'h1234, 16'h0, 0, 1, 0, 0, 0, '0, 1); // R4 clear low
      check(acc_flat_o[71:36] == 36'h0_1234_0000, "R4", 64'(acc_flat_o[71:36]),
            64'h0000000012340000, "clear low");
      // R6: y high from accumulator 1, x from second bus
      cycle(4'd2, 1'b0, 16'h5555, 16'h0, 0, 0, 0, 0, 0, '0, 1);
      cycle(4'd7, 1'b1, 16'h0, 16'h3C3C, 0, 0, 0, 0, 0, '0, 1);
      check(y_o == 32'h1234_5555 && x_o == 16'h3C3C, "R6", 64'({x_o, y_o}),
            64'h3C3C12345555, "y from acc");
      // R12 positive overflow via arithmetic port, stores with and without limiting
      cycle(4'd0, 1'b0, 16'h0, 16'h0, 0, 0, 0, 1, 0, 36'h3_0000_1234, 1);
      cycle(4'd10, 1'b0, 16'h0, 16'h0, 0, 0, 1, 0, 0, '0, 1); // R10 -> 7FFF
      cycle(4'd11, 1'b0, 16'h0, 16'h0, 0, 0, 1, 0, 0, '0, 1); // R10 -> FFFF
      cycle(4'd10, 1'b0, 16'h0, 16'h0, 0, 0, 0, 0, 0, '0, 1); // R9 raw 0000
      // negative overflow
      cycle(4'd0, 1'b0, 16'h0, 16'h0, 0, 0, 0, 1, 1, 36'hC_8000_0001, 1);
      cycle(4'd10, 1'b1, 16'h0, 16'h0, 0, 0, 1, 0, 0, '0, 1); // R10 -> 8000
      check(ybus_o == 16'h8000, "R10", 64'(ybus_o), 64'h8000, "held neg high");
      cycle(4'd11, 1'b1, 16'h0, 16'h0, 0, 0, 1, 0, 0, '0, 1); // R10 -> 0000
      // clean negative value: no limiting even with sat on
      cycle(4'd0, 1'b0, 16'h0, 16'h0, 0, 0, 0, 1, 0, 36'hF_8765_4321, 1);
      cycle(4'd11, 1'b0, 16'h0, 16'h0, 0, 0, 1, 0, 0, '0, 1); // R9 -> 4321
      // R12 collision: bus load wins
      cycle(4'd4, 1'b0, 16'hBEEF, 16'h0, 0, 0, 0, 1, 0, 36'h0_0000_0000, 1);
      check(acc_flat_o[15:0] == 16'hBEEF && acc_flat_o[35:16] == 20'hF8765, "R12",
            64'(acc_flat_o[35:0]), 64'hF8765BEEF, "bus priority");
      // R2 clear option and R11 unused code
      cycle(4'd1, 1'b0, 16'h7777, 16'h0, 1, 0, 0, 0, 0, '0, 1);
      check(y_o == 32'h7777_0000, "R2", 64'(y_o), 64'h77770000, "y clear");
      cycle(4'd14, 1'b0, 16'h1111, 16'h2222, 1, 1, 1, 0, 0, '0, 1); // R11

      // constrained random
      for (int i = 0; i < 3000; i++) begin
         logic [3:0] op;
         op = 4'($urandom_range(0, 15));
         cycle(op, 1'($urandom()), 16'($urandom()), 16'($urandom()), 1'($urandom()),
               1'($urandom()), 1'($urandom()), ($urandom_range(0, 3) == 0),
               1'($urandom()), rand_acc(), 1);
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule